// File: doc/BRIEF.md
# Single-Cycle 32-Bit RISC Core

This block is a single-cycle 32-bit processor core. Each rising clock edge completes one whole instruction: fetch from an internal word array indexed by the program counter, decode, register read, ALU operation, optional data-memory access and write-back. The instruction set is small. It has register-to-register add, subtract, AND, OR and signed set-less-than, plus load word, store word and branch-if-equal.

Field positions never move. The opcode sits in bits 31:26, the two source register numbers sit in bits 25:21 (rs) and 20:16 (rt), and the immediate sits in bits 15:0. Four two-way selectors are each steered by one control line from the main decoder:
- the destination register number comes from rt or rd (bits 15:11);
- the second ALU operand is rt's value or the sign-extended immediate;
- the write-back value is the ALU result or the loaded word;
- the next PC is PC+4 or the branch target.

The main decoder reduces the opcode to a 2-bit ALU class. A separate ALU decoder turns that class, together with the low function bits, into a 3-bit ALU select. Asynchronous debug ports let a bench read any register and any data word.

On reset the core loads its memories with a fixed test image:
- register i holds i;
- data word i holds 100·i;
- the instruction array holds a built-in program.

Top module: `sc_core`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, PC is 0, register i reads i (register 0 reads 0), data word i reads 100·i, and the instruction array holds the built-in program.
- R2: An instruction with opcode 0 writes the register named by bits 15:11. Function code 32 (bits 5:0) writes rs + rt.
- R3: Under opcode 0, the function codes produce these results: 34 gives rs − rt, 36 gives rs AND rt, 37 gives rs OR rt, and 42 gives 1 when rs < rt as signed two's complement, else 0.
- R4: Opcode 35 writes into register rt (bits 20:16) the data word whose index is the low `DM_AW` bits of rs + sign-extended bits 15:0.
- R5: Opcode 43 writes rt's value into the data word indexed by the low `DM_AW` bits of rs + sign-extended offset, on the rising edge. It writes no register.
- R6: Opcode 4 with rs equal to rt sets PC to PC+4 + (sign-extended offset × 4). When rs and rt differ, PC becomes PC+4.
- R7: Register 0 always reads 0 and keeps 0 when an instruction names it as destination.
- R8: The ALU select is {negate-B, op[1:0]}: 010 add, 110 subtract, 000 AND, 001 OR, 111 set-less-than. The ALU class is 00 for loads and stores (add), 01 for branch (subtract) and 10 for opcode 0 (function decoded).
- R9: Every instruction other than a taken branch advances PC by 4. The instruction word is fetched from array entry PC[IM_AW+1:2].
- R10: `dbg_reg_val` and `dbg_mem_val` follow `dbg_reg_sel` and `dbg_mem_sel` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction completes per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads PC and memory image |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_sel | input | DM_AW | Data word index to observe |
| dbg_mem_val | output | 32 | Value of the selected data word |

## Verification
The bench builds the core with IM_AW = 4 and DM_AW = 7. Sixteen instruction words hold the thirteen-word program, which covers all five ALU functions, and 128 data words put the load at index 102 and the store at index 104 within reach.

The program includes these cases:
- a branch that is taken backwards once and then falls through;
- a load with a negative offset;
- a load that reads back the stored word;
- a write aimed at register 0;
- signed comparisons on both sides of zero.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN  = 32;
    localparam int RF_N  = 32;
    localparam int RF_AW = $clog2(RF_N);

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    // ALU select: {negate B, op[1:0]}
    localparam logic [2:0] ALU_AND = 3'b000;
    localparam logic [2:0] ALU_OR  = 3'b001;
    localparam logic [2:0] ALU_ADD = 3'b010;
    localparam logic [2:0] ALU_SUB = 3'b110;
    localparam logic [2:0] ALU_SLT = 3'b111;

    typedef struct packed {
        logic       reg_dst;
        logic       alu_src;
        logic       mem_to_reg;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       branch;
        logic [1:0] alu_op;
    } ctrl_t;

    function automatic logic [31:0] r_word(logic [4:0] rs, logic [4:0] rt,
                                           logic [4:0] rd, logic [5:0] fn);
        return {OPC_RTYPE, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] i_word(logic [5:0] op, logic [4:0] rs,
                                           logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Built-in program image loaded at reset
    function automatic logic [31:0] prog_word(int unsigned idx);
        case (idx)
            0:  return r_word(5'd5, 5'd1, 5'd9, FN_ADD);
            1:  return r_word(5'd9, 5'd6, 5'd9, FN_SUB);
            2:  return i_word(OPC_BEQ, 5'd9, 5'd0, 16'hFFFE);
            3:  return r_word(5'd9, 5'd0, 5'd1, FN_SLT);
            4:  return i_word(OPC_LW, 5'd2, 5'd1, 16'd100);
            5:  return i_word(OPC_SW, 5'd2, 5'd9, 16'd102);
            6:  return r_word(5'd5, 5'd5, 5'd0, FN_ADD);
            7:  return r_word(5'd9, 5'd7, 5'd10, FN_AND);
            8:  return r_word(5'd5, 5'd6, 5'd11, FN_OR);
            9:  return i_word(OPC_LW, 5'd11, 5'd12, 16'hFFFF);
            10: return i_word(OPC_LW, 5'd0, 5'd13, 16'd104);
            11: return r_word(5'd5, 5'd9, 5'd14, FN_SLT);
            12: return r_word(5'd9, 5'd5, 5'd15, FN_SLT);
            default: return 32'd0;
        endcase
    endfunction
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        case (opcode)
            OPC_RTYPE: begin
                ctrl.reg_dst = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_op  = 2'b10;
            end
            OPC_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_rd     = 1'b1;
            end
            OPC_SW: begin
                ctrl.alu_src = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = 2'b01;
            end
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown(opcode)) begin
            AST_ST_NOWB: assert (!(ctrl.mem_wr && ctrl.reg_wr)); // R5
            AST_MEM_EXCL: assert (!(ctrl.mem_wr && ctrl.mem_rd)); // R4
        end
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  logic [1:0] alu_op,
    input  logic [3:0] funct_lo,
    output logic [2:0] alu_sel
);
    logic neg_b, op_hi, op_lo;

    // Minimised equations; class 11 never occurs
    assign neg_b   = alu_op[0] | (alu_op[1] & funct_lo[1]);
    assign op_lo   = alu_op[1] & (funct_lo[0] | funct_lo[3]);
    assign op_hi   = ~alu_op[1] | ~funct_lo[2];
    assign alu_sel = {neg_b, op_hi, op_lo};

    always_comb begin
        if (!$isunknown(alu_op)) begin
            if (alu_op == 2'b01) begin
                AST_BEQ_SUB: assert (alu_sel == ALU_SUB); // R8
            end
            if (alu_op == 2'b00) begin
                AST_LDST_ADD: assert (alu_sel == ALU_ADD); // R8
            end
        end
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   sel,
    output logic [W-1:0] res,
    output logic         zero
);
    logic [W-1:0] b_x, sum;
    logic         ovf, less;

    assign b_x  = sel[2] ? ~b : b;
    assign sum  = a + b_x + {{(W-1){1'b0}}, sel[2]};
    assign ovf  = (a[W-1] == b_x[W-1]) && (sum[W-1] != a[W-1]);
    assign less = sum[W-1] ^ ovf;

    always_comb begin
        case (sel[1:0])
            2'b00:   res = a & b;
            2'b01:   res = a | b;
            2'b10:   res = sum;
            default: res = {{(W-1){1'b0}}, less};
        endcase
    end

    assign zero = (res == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IM_AW = 4,
    parameter int DM_AW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       dbg_reg_sel,
    output logic [31:0]      dbg_reg_val,
    input  logic [DM_AW-1:0] dbg_mem_sel,
    output logic [31:0]      dbg_mem_val
);
    localparam int IM_N = 1 << IM_AW;
    localparam int DM_N = 1 << DM_AW;

    typedef struct packed {
        logic [XLEN-1:0]  pc;
        logic             rf_we;
        logic [RF_AW-1:0] rf_wa;
        logic [XLEN-1:0]  rf_wd;
        logic             dm_we;
        logic [DM_AW-1:0] dm_wa;
        logic [XLEN-1:0]  dm_wd;
    } step_t;

    logic [XLEN-1:0] pc_q;
    logic [31:0]     im_q [IM_N];
    logic [XLEN-1:0] rf_q [RF_N];
    logic [XLEN-1:0] dm_q [DM_N];
    step_t           st_d;

    logic [31:0]      instr;
    logic [RF_AW-1:0] rs_a, rt_a, rd_a;
    logic [XLEN-1:0]  rs_v, rt_v, sext, alu_b, alu_res, mem_rdata;
    logic [XLEN-1:0]  pc_plus4, br_tgt;
    logic [2:0]       alu_sel;
    logic             alu_zero, pc_src;
    logic             shamt_unused;
    ctrl_t            ctrl;

    // Fetch and fixed field split
    assign instr        = im_q[pc_q[IM_AW+1:2]];
    assign rs_a         = instr[25:21];
    assign rt_a         = instr[20:16];
    assign rd_a         = instr[15:11];
    assign shamt_unused = ^instr[10:6];
    assign sext         = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_main_dec u_main_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .alu_op   (ctrl.alu_op),
        .funct_lo (instr[3:0]),
        .alu_sel  (alu_sel)
    );

    // Register reads, r0 hard-wired
    assign rs_v  = (rs_a == '0) ? '0 : rf_q[rs_a];
    assign rt_v  = (rt_a == '0) ? '0 : rf_q[rt_a];
    assign alu_b = ctrl.alu_src ? sext : rt_v;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_v),
        .b    (alu_b),
        .sel  (alu_sel),
        .res  (alu_res),
        .zero (alu_zero)
    );

    assign mem_rdata = ctrl.mem_rd ? dm_q[alu_res[DM_AW-1:0]] : '0;
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_tgt    = pc_plus4 + {sext[XLEN-3:0], 2'b00};
    assign pc_src    = ctrl.branch & alu_zero;

    always_comb begin
        st_d       = '0;
        st_d.pc    = pc_src ? br_tgt : pc_plus4;
        st_d.rf_wa = ctrl.reg_dst ? rd_a : rt_a;
        st_d.rf_we = ctrl.reg_wr && (st_d.rf_wa != '0);
        st_d.rf_wd = ctrl.mem_to_reg ? mem_rdata : alu_res;
        st_d.dm_we = ctrl.mem_wr;
        st_d.dm_wa = alu_res[DM_AW-1:0];
        st_d.dm_wd = rt_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            for (int i = 0; i < IM_N; i++) im_q[i] <= prog_word(i);
            for (int i = 0; i < RF_N; i++) rf_q[i] <= XLEN'(i);
            for (int i = 0; i < DM_N; i++) dm_q[i] <= XLEN'(i * 100);
        end else begin
            pc_q <= st_d.pc;
            if (st_d.rf_we) rf_q[st_d.rf_wa] <= st_d.rf_wd;
            if (st_d.dm_we) dm_q[st_d.dm_wa] <= st_d.dm_wd;
        end
    end

    // Debug observation, combinational
    assign dbg_reg_val = (dbg_reg_sel == '0) ? '0 : rf_q[dbg_reg_sel];
    assign dbg_mem_val = dm_q[dbg_mem_sel];

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_src |=> pc_q == $past(pc_q) + 32'd4); // R9
    AST_BR_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        pc_src |=> pc_q == $past(pc_q) + 32'd4 + {$past(sext[XLEN-3:0]), 2'b00}); // R6
    AST_R0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q[0] == '0); // R7
    AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00); // R9
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
    localparam int CLK_PERIOD = 10;
    localparam int IM_AW = 4;
    localparam int DM_AW = 7;

    logic             clk;
    logic             rst_n;
    logic [4:0]       dbg_reg_sel;
    logic [31:0]      dbg_reg_val;
    logic [DM_AW-1:0] dbg_mem_sel;
    logic [31:0]      dbg_mem_val;

    sc_core #(.IM_AW(IM_AW), .DM_AW(DM_AW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_reg_sel (dbg_reg_sel),
        .dbg_reg_val (dbg_reg_val),
        .dbg_mem_sel (dbg_mem_sel),
        .dbg_mem_val (dbg_mem_val)
    );

    typedef struct {
        bit          is_mem;
        int unsigned addr;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    event chk_ev;
    event mon_done_ev;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    // Monitor: pops expected items, drives the debug selects, compares
    always begin : mon
        exp_t        e;
        logic [31:0] got;
        @(chk_ev);
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            if (e.is_mem) dbg_mem_sel = DM_AW'(e.addr);
            else          dbg_reg_sel = 5'(e.addr);
            #1;
            got = e.is_mem ? dbg_mem_val : dbg_reg_val;
            n_cmp++;
            if (got !== e.val) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", e.tag, got, e.val);
            end
        end
        -> mon_done_ev;
    end

    task automatic exp_reg(int unsigned a, logic [31:0] v, string t);
        exp_t e;
        e.is_mem = 1'b0; e.addr = a; e.val = v; e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic exp_mem(int unsigned a, logic [31:0] v, string t);
        exp_t e;
        e.is_mem = 1'b1; e.addr = a; e.val = v; e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic flush();
        -> chk_ev;
        @(mon_done_ev);
    endtask

    // One instruction retires per rising edge; sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        rst_n       = 1'b1;
        dbg_reg_sel = '0;
        dbg_mem_sel = '0;
        #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_reg(5, 32'd5, "R1 reset r5");
        exp_reg(31, 32'd31, "R1 reset r31");
        exp_reg(0, 32'd0, "R7 reset r0");
        flush();
        @(negedge clk);
        exp_mem(102, 32'd10200, "R1 reset mem102");
        exp_mem(104, 32'd10400, "R10 async mem104");
        flush();
        @(negedge clk);
        rst_n = 1'b1;

        step(); exp_reg(9, 32'd6, "R2 add r9"); flush();
        step(); exp_reg(9, 32'd0, "R3 R8 R9 sub r9"); flush();
        step(); exp_reg(9, 32'd0, "R6 beq taken r9"); flush();
        step(); exp_reg(9, 32'hFFFF_FFFA, "R6 branch back re-sub r9");
                exp_reg(1, 32'd1, "R6 slt skipped r1"); flush();
        step(); exp_reg(9, 32'hFFFF_FFFA, "R6 beq not taken r9"); flush();
        step(); exp_reg(1, 32'd1, "R3 slt neg<0 r1"); flush();
        step(); exp_reg(1, 32'd10200, "R4 lw r1"); flush();
        step(); exp_mem(104, 32'hFFFF_FFFA, "R5 sw mem104");
                exp_reg(9, 32'hFFFF_FFFA, "R5 sw no wb r9");
                exp_reg(1, 32'd10200, "R5 sw no wb r1"); flush();
        step(); exp_reg(0, 32'd0, "R7 write r0 ignored"); flush();
        step(); exp_reg(10, 32'd2, "R3 and r10"); flush();
        step(); exp_reg(11, 32'd7, "R3 or r11"); flush();
        step(); exp_reg(12, 32'd600, "R4 lw neg offset r12"); flush();
        step(); exp_reg(13, 32'hFFFF_FFFA, "R4 lw readback r13"); flush();
        step(); exp_reg(14, 32'd0, "R3 slt 5<-6 r14"); flush();
        step(); exp_reg(15, 32'd1, "R3 slt -6<5 r15");
                exp_mem(6, 32'd600, "R10 mem6 intact"); flush();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 1000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule